// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Interval Timer

This block holds two 8-bit up-counters, each paired with an 8-bit compare register. In separate mode they act as two independent interval timers, each with its own clock-select field. In cascaded mode they form one 16-bit interval timer. The low counter then carries into the high counter, and the full 16-bit compare clears both. Each timer drives a single-cycle interrupt pulse, which has its own mask bit, and a toggle output that inverts on every compare hit.

The count clock of each timer is set by a 4-bit code. The code picks either an edge of a synchronised external event input or a power-of-two division of the system clock. Codes outside the defined set stop the counter. A read strobe captures both count bytes in the same cycle, so software always sees a consistent 16-bit value.

Top module: `dual_interval_timer`

## Requirements
- R1: The clock-select code maps as follows. 4'b0000 counts on each rising edge of `evt_in`. 4'b0001 counts on each falling edge. A code c from 4'b0110 to 4'b1110 counts once every 2^(c-4) system clocks. 4'b1111 counts once every 4096 system clocks.
- R2: Codes 4'b0010 to 4'b0101 produce no count tick, and the counter they drive holds its value.
- R3: In separate mode (`cascade`=0), a counter that receives a tick while equal to its compare value returns to zero. The timer interrupts once every (compare+1) ticks. The high timer uses `csel_hi`.
- R4: In cascaded mode (`cascade`=1), both counters count on `csel_lo` ticks. The high byte advances when the low byte steps from 0xFF to 0x00. A tick while {high,low} equals {`cmp_hi`,`cmp_lo`} clears both and raises the high event. The interval is value+1 ticks, from 1 to 65536.
- R5: In cascaded mode, a tick while the low byte equals `cmp_lo` still raises the low event, without clearing the low byte.
- R6: A set mask bit suppresses that timer's interrupt pulse, but its toggle output still inverts.
- R7: An interrupt is a one-cycle pulse, asserted in the cycle after the counting edge.
- R8: Each toggle output inverts once per event of its timer. It is 0 after reset.
- R9: While `enable` is 0, both counters and the clock divider are held at zero and no interrupt is raised.
- R10: When `rd_req` is high at a clock edge, `rd_data` takes {high count, low count} from that same cycle. Otherwise `rd_data` holds its value.
- R11: `evt_in` passes through a two-stage synchroniser and an edge detector. A counted edge is visible in the count within four clocks. After reset, the counts, compares, `rd_data`, interrupts and toggles are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Asynchronous external event input |
| enable | input | 1 | Run enable; 0 clears and holds both counters |
| cascade | input | 1 | 0 = two 8-bit timers, 1 = one 16-bit timer |
| csel_lo | input | 4 | Clock-select code, low timer (and the pair when cascaded) |
| csel_hi | input | 4 | Clock-select code, high timer in separate mode |
| cmp_lo_we | input | 1 | Write strobe for the low compare register |
| cmp_hi_we | input | 1 | Write strobe for the high compare register |
| cmp_wdata | input | 8 | Compare write data |
| mask_lo | input | 1 | Suppresses the low timer's interrupt |
| mask_hi | input | 1 | Suppresses the high timer's interrupt |
| rd_req | input | 1 | Capture strobe for the 16-bit count snapshot |
| rd_data | output | 16 | Captured {high, low} count |
| irq_lo | output | 1 | Low timer interrupt pulse |
| irq_hi | output | 1 | High timer interrupt pulse |
| tog_lo | output | 1 | Low timer toggle output |
| tog_hi | output | 1 | High timer toggle output |

## Verification
Latency from each stimulus:
- A count tick changes the count at the same edge, and the interrupt follows one cycle later.
- An `evt_in` edge reaches the count within four cycles.
- A snapshot appears one cycle after `rd_req`.

The bench avoids absolute timing for interval checks. It measures the gap between consecutive interrupt pulses, so the fixed latency cancels out, and it compares that gap with (compare+1) times the tick period. Snapshot checks are taken only after the counters are frozen, or at least six cycles after the last event edge. Before any measurement, counters are cleared by dropping `enable`.

// File: rtl/dit_pkg.sv
// Package: shared constants, clock-select types and decode helpers for the
// dual interval timer. Assumes a 4-bit select code and a 12-bit divider.
package dit_pkg;
    localparam int CSEL_W  = 4;
    localparam int DIV_LOG = 12;

    typedef logic [CSEL_W-1:0] csel_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_DIV  = 2'd3
    } src_e;

    // Classify a select code into its count source.
    function automatic src_e csel_source(csel_t c);
        src_e s;
        if (c == 4'b0000)              s = SRC_RISE;
        else if (c == 4'b0001)         s = SRC_FALL;
        else if (c inside {[4'b0110:4'b1111]}) s = SRC_DIV;
        else                           s = SRC_NONE;
        return s;
    endfunction

    // Power-of-two exponent of the divider for a division code.
    function automatic int unsigned csel_log2(csel_t c);
        int unsigned v;
        if (c == 4'b1111) v = DIV_LOG;
        else              v = int'(c) - 4;
        return v;
    endfunction
endpackage

// File: rtl/dit_divider.sv
// Free-running system-clock divider shared by both timers.
// Assumes: cleared and held at zero while the timer is disabled.
module dit_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    output logic [DIV_W-1:0] div_cnt
);
    // Advance the divider each cycle while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) div_cnt <= '0;
        else                   div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/dit_edge_sync.sv
// Synchroniser and edge detector for the asynchronous event input.
// Assumes: event pulses stay stable for at least two clocks per level.
module dit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic ev_rise,
    output logic ev_fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], evt_in};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign ev_rise =  sync_q[STAGES-1] & ~last_q;
    assign ev_fall = ~sync_q[STAGES-1] &  last_q;
endmodule

// File: rtl/dit_tick_sel.sv
// Per-timer clock selector: turns a select code into a one-cycle count tick.
// Assumes: the divider counts every cycle while enabled, so a divide-by-2^k
// tick appears when its low k bits are all ones.
module dit_tick_sel
    import dit_pkg::*;
#(
    parameter int DIV_W = DIV_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  csel_t            csel,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic [DIV_W-1:0] div_cnt,
    output logic             tick
);
    localparam int SH_W = $clog2(DIV_W + 1);

    logic [DIV_W:0] ones;
    logic [SH_W-1:0] shift;
    src_e            src;

    assign ones[0] = 1'b0;
    for (genvar k = 1; k <= DIV_W; k++) begin : g_ones
        assign ones[k] = &div_cnt[k-1:0];
    end

    assign src   = csel_source(csel);
    assign shift = SH_W'(csel_log2(csel));

    // Pick the tick source named by the select code.
    always_comb begin
        case (src)
            SRC_RISE: tick = enable & ev_rise;
            SRC_FALL: tick = enable & ev_fall;
            SRC_DIV:  tick = enable & ones[shift];
            default:  tick = 1'b0;
        endcase
    end

    // Divided ticks are at least four cycles apart.
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && src == SRC_DIV && $stable(csel)) |=> !tick); // R1
endmodule

// File: rtl/dit_counter.sv
// 8-bit up-counter with synchronous clear; the clear has priority.
// Assumes: control decisions (wrap, carry, match) are made by the parent.
module dit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Clear, step or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (inc)        count <= count + 1'b1;
    end
endmodule

// File: rtl/dual_interval_timer.sv
// Top: two 8-bit interval timers that can be chained into one 16-bit timer.
// Assumes: the compare registers are written while the timer is stopped or
// at a safe point; cascaded mode uses the low select code for both bytes.
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_in,
    input  logic               enable,
    input  logic               cascade,
    input  logic [3:0]         csel_lo,
    input  logic [3:0]         csel_hi,
    input  logic               cmp_lo_we,
    input  logic               cmp_hi_we,
    input  logic [CNT_W-1:0]   cmp_wdata,
    input  logic               mask_lo,
    input  logic               mask_hi,
    input  logic               rd_req,
    output logic [2*CNT_W-1:0] rd_data,
    output logic               irq_lo,
    output logic               irq_hi,
    output logic               tog_lo,
    output logic               tog_hi
);
    localparam int N_CH  = 2;
    localparam int LO    = 0;
    localparam int HI    = 1;
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [DIV_LOG-1:0] div_cnt;
    logic               ev_rise, ev_fall;
    csel_t              csel   [N_CH];
    logic [CNT_W-1:0]   cnt    [N_CH];
    logic [CNT_W-1:0]   cmp_q  [N_CH];
    logic [N_CH-1:0]    tick, clr, inc, ev, mask_v, cmp_we;
    logic [N_CH-1:0]    irq_q, tog_q;
    logic               hit_lo8, hit_hi8, hit16, full_hit;

    assign csel[LO]  = csel_lo;
    assign csel[HI]  = csel_hi;
    assign mask_v    = {mask_hi, mask_lo};
    assign cmp_we    = {cmp_hi_we, cmp_lo_we};

    dit_divider #(.DIV_W(DIV_LOG)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_cnt (div_cnt)
    );

    dit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (evt_in),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dit_tick_sel #(.DIV_W(DIV_LOG)) u_tsel (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .csel    (csel[g]),
            .ev_rise (ev_rise),
            .ev_fall (ev_fall),
            .div_cnt (div_cnt),
            .tick    (tick[g])
        );

        dit_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clr[g]),
            .inc   (inc[g]),
            .count (cnt[g])
        );

        // Hold the compare value written by software.
        always_ff @(posedge clk) begin
            if (!rst_n)         cmp_q[g] <= '0;
            else if (cmp_we[g]) cmp_q[g] <= cmp_wdata;
        end

        // Turn each timer event into a masked pulse and a toggle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q[g] <= 1'b0;
                tog_q[g] <= 1'b0;
            end else begin
                irq_q[g] <= ev[g] & ~mask_v[g];
                tog_q[g] <= tog_q[g] ^ ev[g];
            end
        end

        AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q[g] |=> !irq_q[g]); // R7
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q[g] |-> !$past(mask_v[g])); // R6
        AST_TOG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            (tog_q[g] != $past(tog_q[g])) |-> $past(ev[g])); // R8
    end

    assign hit_lo8  = (cnt[LO] == cmp_q[LO]);
    assign hit_hi8  = (cnt[HI] == cmp_q[HI]);
    assign hit16    = hit_lo8 & hit_hi8;
    assign full_hit = cascade & tick[LO] & hit16;

    // Decide clear, step and event for both counters per mode.
    always_comb begin
        ev[LO] = tick[LO] & hit_lo8;
        if (cascade) begin
            clr[LO] = !enable | full_hit;
            inc[LO] = tick[LO];
            clr[HI] = !enable | full_hit;
            inc[HI] = tick[LO] & (cnt[LO] == ALL_ONES);
            ev[HI]  = full_hit;
        end else begin
            clr[LO] = !enable | (tick[LO] & hit_lo8);
            inc[LO] = tick[LO];
            clr[HI] = !enable | (tick[HI] & hit_hi8);
            inc[HI] = tick[HI];
            ev[HI]  = tick[HI] & hit_hi8;
        end
    end

    // Capture both count bytes in one cycle on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= {cnt[HI], cnt[LO]};
    end

    assign irq_lo = irq_q[LO];
    assign irq_hi = irq_q[HI];
    assign tog_lo = tog_q[LO];
    assign tog_hi = tog_q[HI];

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt[LO] == '0 && cnt[HI] == '0)); // R9
    AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cascade && csel_source(csel_hi) == SRC_NONE)
        |=> cnt[HI] == $past(cnt[HI])); // R2
    AST_HI_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cascade && tick[LO] && cnt[LO] == ALL_ONES && !hit16)
        |=> cnt[HI] == $past(cnt[HI]) + 1'b1); // R4
    AST_LO_KEEPS_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cascade && tick[LO] && hit_lo8 && !hit_hi8)
        |=> cnt[LO] == $past(cnt[LO]) + 1'b1); // R5
    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_data == {$past(cnt[HI]), $past(cnt[LO])}); // R10
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0, enable = 1'b0, cascade = 1'b0;
    logic [3:0]  csel_lo = 4'b0010, csel_hi = 4'b0010;
    logic        cmp_lo_we = 1'b0, cmp_hi_we = 1'b0;
    logic [7:0]  cmp_wdata = 8'h00;
    logic        mask_lo = 1'b0, mask_hi = 1'b0, rd_req = 1'b0;
    logic [15:0] rd_data;
    logic        irq_lo, irq_hi, tog_lo, tog_hi;

    int checks = 0, errors = 0, cyc = 0;
    int q_lo[$], q_hi[$];
    string tag_lo = "", tag_hi = "";
    bit lo_armed = 0, hi_armed = 0;
    int lo_last = 0, hi_last = 0;
    int n_irq_lo = 0, n_irq_hi = 0, n_tog_lo = 0, n_tog_hi = 0;
    logic p_irq_lo = 0, p_irq_hi = 0, p_tog_lo = 0, p_tog_hi = 0;

    dual_interval_timer u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .enable(enable),
        .cascade(cascade), .csel_lo(csel_lo), .csel_hi(csel_hi),
        .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .cmp_wdata(cmp_wdata),
        .mask_lo(mask_lo), .mask_hi(mask_hi), .rd_req(rd_req),
        .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi),
        .tog_lo(tog_lo), .tog_hi(tog_hi)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures interrupt gaps and pops expected gaps from the queues.
    always @(negedge clk) begin
        cyc++;
        if (irq_lo) begin
            n_irq_lo++;
            if (p_irq_lo) begin errors++; $display("FAIL R7: irq_lo high 2 cycles, actual 2 expected 1"); end
            if (lo_armed && q_lo.size() > 0) begin
                int e; e = q_lo.pop_front(); checks++;
                if (cyc - lo_last != e) begin errors++;
                    $display("FAIL %s: low gap actual %0d expected %0d", tag_lo, cyc - lo_last, e); end
            end
            lo_last = cyc; lo_armed = 1;
        end
        if (irq_hi) begin
            n_irq_hi++;
            if (p_irq_hi) begin errors++; $display("FAIL R7: irq_hi high 2 cycles, actual 2 expected 1"); end
            if (hi_armed && q_hi.size() > 0) begin
                int e; e = q_hi.pop_front(); checks++;
                if (cyc - hi_last != e) begin errors++;
                    $display("FAIL %s: high gap actual %0d expected %0d", tag_hi, cyc - hi_last, e); end
            end
            hi_last = cyc; hi_armed = 1;
        end
        if (tog_lo != p_tog_lo) n_tog_lo++;
        if (tog_hi != p_tog_hi) n_tog_hi++;
        p_irq_lo = irq_lo; p_irq_hi = irq_hi; p_tog_lo = tog_lo; p_tog_hi = tog_hi;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic read16(output int v);
        rd_req = 1'b1; step(1); rd_req = 1'b0; v = int'(rd_data);
    endtask

    // Driver: stop, configure, restart and disarm the monitor.
    task automatic cfg(bit casc, logic [3:0] cl, logic [3:0] ch, logic [7:0] cml, logic [7:0] cmh,
                       bit ml, bit mh);
        enable = 1'b0; step(1);
        cascade = casc; csel_lo = cl; csel_hi = ch; mask_lo = ml; mask_hi = mh;
        cmp_wdata = cml; cmp_lo_we = 1'b1; step(1); cmp_lo_we = 1'b0;
        cmp_wdata = cmh; cmp_hi_we = 1'b1; step(1); cmp_hi_we = 1'b0;
        q_lo.delete(); q_hi.delete(); lo_armed = 0; hi_armed = 0;
        enable = 1'b1;
    endtask

    task automatic push(bit hi, int gap, int n, string tag);
        for (int i = 0; i < n; i++) begin
            if (hi) q_hi.push_back(gap); else q_lo.push_back(gap);
        end
        if (hi) tag_hi = tag; else tag_lo = tag;
    endtask

    task automatic drain(int limit);
        int t = 0;
        while ((q_lo.size() > 0 || q_hi.size() > 0) && t < limit) begin step(1); t++; end
        if (q_lo.size() > 0 || q_hi.size() > 0) begin
            errors++;
            $display("FAIL %s/%s: pending gaps actual %0d expected 0", tag_lo, tag_hi,
                     q_lo.size() + q_hi.size());
            q_lo.delete(); q_hi.delete();
        end
    endtask

    initial begin
        int v, a, b, t0;
        step(3); rst_n = 1'b1; step(1);
        // R11 reset state
        read16(v); check("R11 reset count", v, 0);
        check("R11 reset irq", int'(irq_lo) + int'(irq_hi), 0);
        check("R11 reset toggles", int'(tog_lo) + int'(tog_hi), 0);

        // R3 separate mode, R1 divide 4 and 8
        cfg(0, 4'b0110, 4'b0111, 8'd9, 8'd2, 0, 0);
        push(0, 40, 3, "R3 low /4 cmp 9"); push(1, 24, 3, "R3 high /8 cmp 2");
        drain(400);

        // R1 other division codes
        cfg(0, 4'b1000, 4'b0010, 8'd0, 8'd0, 0, 0);
        push(0, 16, 3, "R1 code 1000"); drain(200);
        cfg(0, 4'b1110, 4'b0010, 8'd0, 8'd0, 0, 0);
        push(0, 1024, 2, "R1 code 1110"); drain(4000);
        cfg(0, 4'b1111, 4'b0010, 8'd0, 8'd0, 0, 0);
        push(0, 4096, 1, "R1 code 1111"); drain(9000);

        // R2 prohibited code on high timer
        cfg(0, 4'b0110, 4'b0011, 8'hFF, 8'd0, 0, 0);
        a = n_irq_hi; step(200); read16(v);
        check("R2 high byte held", v >> 8, 0);
        check("R2 no high irq", n_irq_hi - a, 0);
        check("R2 low byte counting", int'(v[7:0] != 0), 1);
        // R2 both prohibited: frozen, R10 snapshot holds
        csel_lo = 4'b0101; step(2); read16(a); step(50); read16(b);
        check("R2 frozen count", b, a);
        csel_lo = 4'b0110; step(40);
        check("R10 rd_data held without strobe", int'(rd_data), b);
        read16(v); check("R10 fresh snapshot differs", int'(v != b), 1);

        // R1/R11 event polarity
        cfg(0, 4'b0000, 4'b0010, 8'hFF, 8'hFF, 0, 0);
        evt_in = 1'b1; step(4); read16(v); check("R1 R11 rising counted", v, 1);
        evt_in = 1'b0; step(6); read16(v); check("R1 falling ignored by 0000", v, 1);
        cfg(0, 4'b0001, 4'b0010, 8'hFF, 8'hFF, 0, 0);
        step(4);
        evt_in = 1'b1; step(6); read16(v); check("R1 rising ignored by 0001", v, 0);
        evt_in = 1'b0; step(6); read16(v); check("R1 falling counted", v, 1);

        // R4 cascaded carry with events, R10 16-bit read
        cfg(1, 4'b0000, 4'b0010, 8'hFF, 8'hFF, 0, 0);
        step(4);
        for (int i = 0; i < 300; i++) begin evt_in = 1'b1; step(3); evt_in = 1'b0; step(3); end
        step(6); read16(v); check("R4 R10 cascaded count", v, 300);

        // R4/R5 cascaded interval 0x0103 at /4
        cfg(1, 4'b0110, 4'b0010, 8'h03, 8'h01, 0, 0);
        push(1, 1040, 2, "R4 16-bit interval");
        q_lo.push_back(1024); q_lo.push_back(16); q_lo.push_back(1024); tag_lo = "R5 low hit in cascade";
        drain(5000);
        // R6 mask with R8 toggles still running
        mask_lo = 1'b1; mask_hi = 1'b1; step(20);
        a = n_irq_lo + n_irq_hi; t0 = n_tog_lo; b = n_tog_hi;
        step(2080);
        check("R6 masked irqs", n_irq_lo + n_irq_hi - a, 0);
        check("R6 R8 low toggles under mask", n_tog_lo - t0, 4);
        check("R8 high toggles", n_tog_hi - b, 2);

        // R4 shortest and a longer cascaded interval
        cfg(1, 4'b0110, 4'b0010, 8'h00, 8'h00, 0, 0);
        push(1, 4, 3, "R4 shortest interval"); push(0, 4, 3, "R5 low every tick"); drain(100);
        cfg(1, 4'b0110, 4'b0010, 8'hFF, 8'h02, 1, 0);
        push(1, 3072, 1, "R4 interval 0x02FF"); drain(7000);

        // R9 disable clears and holds
        step(300); enable = 1'b0; step(2); read16(v); check("R9 cleared", v, 0);
        a = n_irq_lo + n_irq_hi; step(100); read16(v);
        check("R9 held at zero", v, 0);
        check("R9 no irq while disabled", n_irq_lo + n_irq_hi - a, 0);

        summary();
    end
endmodule